// File: doc/BRIEF.md
# CAN Message FIFO Pair with Mailbox Windows

This block holds the two message queues that sit between a CAN controller's protocol engine and the CPU. One queue carries frames from the CPU to the transmitter. The other carries frames from the receiver to the CPU. Each queue holds `DEPTH` entries. An entry is a 32-bit identifier word, a 4-bit data length code, eight data bytes and a 16-bit timestamp.

The CPU never addresses the queue storage directly. It sees one fixed mailbox window per direction in a word-addressed register space. Mailbox `TX_MBX` (56) is a staging area that the CPU fills. Mailbox `RX_MBX` (60) shows the oldest received entry. The CPU moves its side of a queue by writing the value 0xFF to that direction's pointer register. A transmit pointer write commits the staged entry, and a receive pointer write releases the entry on show.

On the CAN side, frames leave the transmit queue and enter the receive queue through valid/ready handshakes. Each direction raises a flag in an interrupt status register. The flags are masked by an enable register onto one interrupt line.

Top module: `can_msg_fifo_pair`

## Requirements
- R1: After reset the registers read as follows: transmit control 0x00, receive control 0x80 (empty, disabled), interrupt status 0 and interrupt enable 0. After reset `irq`, `tx_valid`, `rx_ready` and `rx_overrun` are all low.
- R2: Word address = mailbox×4 + word. Word 0 is the ID, word 1 is data bytes 0–3 (byte k at bits 8k+7:8k), word 2 is data bytes 4–7, and word 3 is {timestamp[31:16], DLC[3:0]}. Writes to mailbox 56 fill the staging entry, which reads back unchanged. Writing 0xFF to the transmit pointer register (0x102) commits the staged entry. Any other value has no effect. A commit raises the unsent count in transmit control bits 3:1 (bit 0 = enable).
- R3: A commit while the transmit queue holds `DEPTH` entries is ignored. It sets sticky bit 4 of transmit control. Writing transmit control with bit 4 = 1 clears that bit.
- R4: `tx_valid` is high exactly when transmit is enabled and the queue is not empty. The `tx_*` fields show the oldest entry. A `tx_valid && tx_ready` cycle removes it, so entries leave in commit order.
- R5: A receive push is `rx_valid && rx_ready`, and `rx_ready` equals receive enable. A push stores the frame. Mailbox 60 shows the oldest stored frame. Writing 0xFF to the receive pointer register (0x103) releases that frame.
- R6: A release while the receive queue is empty is ignored. It sets sticky bit 4 of receive control. Writing receive control with bit 4 = 1 clears that bit.
- R7: A push into a full receive queue drops the frame. It pulses `rx_overrun` high for exactly one cycle, in the cycle after the push.
- R8: Receive control (0x101) bit 7 reads 1 when the queue is empty. Its bits 3:1 give the number of stored frames.
- R9: Interrupt status (0x104) bit 3 is set on every transmit pop and bit 4 on every receive push. Writing the register clears each of these bits that is written as 0. Interrupt enable (0x105) uses the same bit positions. `irq` is the OR of the enabled flags, one cycle after a flag changes.
- R10: Clearing an enable bit empties that queue. While receive is disabled, `rx_ready` is low and pushes are ignored. While transmit is disabled, commits are ignored.
- R11: The ID word is stored and returned unchanged, including bit 31 (extended ID) and bit 30 (remote request). The DLC field keeps only bits 3:0, so the upper bits of its byte read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Registered read data for the address of the previous cycle |
| rx_valid | input | 1 | Received frame offered |
| rx_ready | output | 1 | Receive queue accepting (enabled) |
| rx_id | input | 32 | Received ID word |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received data bytes |
| rx_ts | input | 16 | Received timestamp |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Transmitter takes the entry |
| tx_id | output | 32 | Oldest transmit ID word |
| tx_dlc | output | 4 | Oldest transmit data length code |
| tx_data | output | 64 | Oldest transmit data bytes |
| tx_ts | output | 16 | Oldest transmit timestamp |
| rx_overrun | output | 1 | One-cycle pulse on a dropped receive frame |
| irq | output | 1 | Interrupt request |

## Verification
A CPU write or a CAN-side handshake takes effect at the edge that samples it. Read data is registered, so a read started after that edge returns the new state one cycle later. The bench drives inputs on falling edges and samples on the falling edge after the read. `rx_overrun` and the interrupt status flags are due at the first falling edge after the triggering edge, and `irq` is due one cycle after that. The bench checks `irq` at both points to pin the extra register stage. The bench sweeps each queue from empty through full and one past full, and it checks the order and every field of each entry against an arithmetic frame pattern.

// File: rtl/can_fifo_pkg.sv
package can_fifo_pkg;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [15:0] ts;
  } can_entry_t;

  localparam logic [7:0] ADV_KEY    = 8'hFF;
  localparam int         EN_BIT     = 0;
  localparam int         STICKY_BIT = 4;
  localparam int         EMPTY_BIT  = 7;
  localparam int         ISR_TX_BIT = 3;
  localparam int         ISR_RX_BIT = 4;

  localparam logic [2:0] SEL_TXCTL = 3'd0;
  localparam logic [2:0] SEL_RXCTL = 3'd1;
  localparam logic [2:0] SEL_TXPTR = 3'd2;
  localparam logic [2:0] SEL_RXPTR = 3'd3;
  localparam logic [2:0] SEL_ISR   = 3'd4;
  localparam logic [2:0] SEL_IER   = 3'd5;

  function automatic logic [31:0] entry_word(input can_entry_t e, input logic [1:0] w);
    case (w)
      2'd0:    entry_word = e.id;
      2'd1:    entry_word = e.data[31:0];
      2'd2:    entry_word = e.data[63:32];
      default: entry_word = {e.ts, 12'h000, e.dlc};
    endcase
  endfunction

endpackage

// File: rtl/can_msg_fifo.sv
module can_msg_fifo
  import can_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  can_entry_t    push_entry,
  input  logic          pop,
  output can_entry_t    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  can_entry_t    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    step = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  assign head  = mem[rp];
  assign count = cnt;

endmodule

// File: rtl/can_fifo_window.sv
module can_fifo_window
  import can_fifo_pkg::*;
#(
  parameter int AW     = 9,
  parameter int TX_MBX = 56,
  parameter int RX_MBX = 60,
  localparam int MW = AW - 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  input  can_entry_t    rx_head,
  input  logic [7:0]    tx_ctl_rd,
  input  logic [7:0]    rx_ctl_rd,
  input  logic [7:0]    isr_rd,
  input  logic [7:0]    ier_rd,
  output can_entry_t    tx_stage,
  output logic [31:0]   cpu_rdata
);

  logic          is_ctrl;
  logic [MW-1:0] mbx;
  logic [1:0]    wsel;
  logic          hit_tx, hit_rx;
  logic [31:0]   rd_next;

  assign is_ctrl = cpu_addr[AW-1];
  assign mbx     = cpu_addr[AW-2:2];
  assign wsel    = cpu_addr[1:0];
  assign hit_tx  = !is_ctrl && (mbx == MW'(TX_MBX));
  assign hit_rx  = !is_ctrl && (mbx == MW'(RX_MBX));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_stage <= '0;
    end else if (cpu_we && hit_tx) begin
      case (wsel)
        2'd0: tx_stage.id          <= cpu_wdata;
        2'd1: tx_stage.data[31:0]  <= cpu_wdata;
        2'd2: tx_stage.data[63:32] <= cpu_wdata;
        default: begin
          tx_stage.dlc <= cpu_wdata[3:0];
          tx_stage.ts  <= cpu_wdata[31:16];
        end
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    if (is_ctrl) begin
      case (cpu_addr[2:0])
        SEL_TXCTL: rd_next = {24'h0, tx_ctl_rd};
        SEL_RXCTL: rd_next = {24'h0, rx_ctl_rd};
        SEL_ISR:   rd_next = {24'h0, isr_rd};
        SEL_IER:   rd_next = {24'h0, ier_rd};
        default:   rd_next = '0;
      endcase
    end else if (hit_tx) begin
      rd_next = entry_word(tx_stage, wsel);
    end else if (hit_rx) begin
      rd_next = entry_word(rx_head, wsel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_next;
  end

endmodule

// File: rtl/can_fifo_irq.sv
module can_fifo_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_evt,
  input  logic       rx_evt,
  input  logic       isr_we,
  input  logic       ier_we,
  input  logic [1:0] wbits,
  output logic       isr_tx,
  output logic       isr_rx,
  output logic       ie_tx,
  output logic       ie_rx,
  output logic       irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_tx <= 1'b0;
      isr_rx <= 1'b0;
      ie_tx  <= 1'b0;
      ie_rx  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      isr_tx <= tx_evt || (isr_tx && !(isr_we && !wbits[0]));
      isr_rx <= rx_evt || (isr_rx && !(isr_we && !wbits[1]));
      if (ier_we) begin
        ie_tx <= wbits[0];
        ie_rx <= wbits[1];
      end
      irq <= (isr_tx && ie_tx) || (isr_rx && ie_rx);
    end
  end

endmodule

// File: rtl/can_msg_fifo_pair.sv
module can_msg_fifo_pair
  import can_fifo_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int AW     = 9,
  parameter int TX_MBX = 56,
  parameter int RX_MBX = 60,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [31:0]   rx_id,
  input  logic [3:0]    rx_dlc,
  input  logic [63:0]   rx_data,
  input  logic [15:0]   rx_ts,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_id,
  output logic [3:0]    tx_dlc,
  output logic [63:0]   tx_data,
  output logic [15:0]   tx_ts,
  output logic          rx_overrun,
  output logic          irq
);

  logic          tx_en_q, rx_en_q, tx_ovf_q, rx_unf_q;
  logic          ctrl_we;
  logic [2:0]    sel;
  logic          adv_ok;
  logic          tx_commit, rx_release, tx_pop, rx_push;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  can_entry_t    tx_stage, tx_head, rx_head, rx_in;
  logic          isr_tx, isr_rx, ie_tx, ie_rx;
  logic [7:0]    tx_ctl_rd, rx_ctl_rd, isr_rd, ier_rd;

  assign ctrl_we = cpu_we && cpu_addr[AW-1] && (cpu_addr[AW-2:3] == '0);
  assign sel     = cpu_addr[2:0];
  assign adv_ok  = (cpu_wdata[7:0] == ADV_KEY);

  assign tx_commit  = ctrl_we && (sel == SEL_TXPTR) && adv_ok && tx_en_q;
  assign rx_release = ctrl_we && (sel == SEL_RXPTR) && adv_ok;
  assign tx_pop     = tx_valid && tx_ready;
  assign rx_push    = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q    <= 1'b0;
      rx_en_q    <= 1'b0;
      tx_ovf_q   <= 1'b0;
      rx_unf_q   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (ctrl_we && sel == SEL_TXCTL) tx_en_q <= cpu_wdata[EN_BIT];
      if (ctrl_we && sel == SEL_RXCTL) rx_en_q <= cpu_wdata[EN_BIT];

      if (tx_commit && tx_full)
        tx_ovf_q <= 1'b1;
      else if (ctrl_we && sel == SEL_TXCTL && cpu_wdata[STICKY_BIT])
        tx_ovf_q <= 1'b0;

      if (rx_release && rx_empty)
        rx_unf_q <= 1'b1;
      else if (ctrl_we && sel == SEL_RXCTL && cpu_wdata[STICKY_BIT])
        rx_unf_q <= 1'b0;

      rx_overrun <= rx_push && rx_full;
    end
  end

  assign rx_ready = rx_en_q;

  can_msg_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(!tx_en_q),
    .push(tx_commit), .push_entry(tx_stage),
    .pop(tx_pop), .head(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign rx_in = '{id: rx_id, dlc: rx_dlc, data: rx_data, ts: rx_ts};

  can_msg_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(!rx_en_q),
    .push(rx_push), .push_entry(rx_in),
    .pop(rx_release), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = tx_en_q && !tx_empty;
  assign tx_id    = tx_head.id;
  assign tx_dlc   = tx_head.dlc;
  assign tx_data  = tx_head.data;
  assign tx_ts    = tx_head.ts;

  can_fifo_irq u_irq (
    .clk(clk), .rst(rst),
    .tx_evt(tx_pop), .rx_evt(rx_push && !rx_full),
    .isr_we(ctrl_we && sel == SEL_ISR),
    .ier_we(ctrl_we && sel == SEL_IER),
    .wbits({cpu_wdata[ISR_RX_BIT], cpu_wdata[ISR_TX_BIT]}),
    .isr_tx(isr_tx), .isr_rx(isr_rx),
    .ie_tx(ie_tx), .ie_rx(ie_rx),
    .irq(irq)
  );

  always_comb begin
    tx_ctl_rd = '0;
    tx_ctl_rd[EN_BIT]     = tx_en_q;
    tx_ctl_rd[3:1]        = 3'(tx_cnt);
    tx_ctl_rd[STICKY_BIT] = tx_ovf_q;
    rx_ctl_rd = '0;
    rx_ctl_rd[EN_BIT]     = rx_en_q;
    rx_ctl_rd[3:1]        = 3'(rx_cnt);
    rx_ctl_rd[STICKY_BIT] = rx_unf_q;
    rx_ctl_rd[EMPTY_BIT]  = rx_empty;
    isr_rd = '0;
    isr_rd[ISR_TX_BIT] = isr_tx;
    isr_rd[ISR_RX_BIT] = isr_rx;
    ier_rd = '0;
    ier_rd[ISR_TX_BIT] = ie_tx;
    ier_rd[ISR_RX_BIT] = ie_rx;
  end

  can_fifo_window #(.AW(AW), .TX_MBX(TX_MBX), .RX_MBX(RX_MBX)) u_window (
    .clk(clk), .rst(rst),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rx_head(rx_head),
    .tx_ctl_rd(tx_ctl_rd), .rx_ctl_rd(rx_ctl_rd),
    .isr_rd(isr_rd), .ier_rd(ier_rd),
    .tx_stage(tx_stage), .cpu_rdata(cpu_rdata)
  );

endmodule

// File: rtl/can_fifo_pair_chk.sv
module can_fifo_pair_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 9,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [31:0]   cpu_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_overrun,
  input logic          tx_en,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_ovf,
  input logic          isr_tx
);

  localparam logic [AW-1:0] TXCTL_ADDR = AW'(1 << (AW - 1));

  p_tx_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CW'(DEPTH));

  p_rx_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));

  p_tx_valid_gate_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_en && tx_cnt != '0));

  p_ovf_clear_only_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ovf) |-> $past(cpu_we && cpu_addr == TXCTL_ADDR && cpu_wdata[4]));

  p_overrun_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> $past(rx_valid && rx_ready && rx_cnt == CW'(DEPTH)));

  p_overrun_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> !rx_overrun || $past(rx_valid && rx_ready && rx_cnt == CW'(DEPTH)));

  p_rx_disabled_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && $past(!rx_ready)) |-> rx_cnt == '0);

  p_tx_flag_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(isr_tx) |-> $past(tx_valid && tx_ready));

endmodule

bind can_msg_fifo_pair can_fifo_pair_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_overrun(rx_overrun),
  .tx_en(tx_en_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_ovf(tx_ovf_q), .isr_tx(isr_tx)
);

// File: tb/tb_can_msg_fifo_pair.sv
module tb_can_msg_fifo_pair;

  localparam int DEPTH = 4;
  localparam int AW    = 9;
  localparam logic [AW-1:0] TXW   = 9'd224;
  localparam logic [AW-1:0] RXW   = 9'd240;
  localparam logic [AW-1:0] TXCTL = 9'd256;
  localparam logic [AW-1:0] RXCTL = 9'd257;
  localparam logic [AW-1:0] TXPTR = 9'd258;
  localparam logic [AW-1:0] RXPTR = 9'd259;
  localparam logic [AW-1:0] ISR   = 9'd260;
  localparam logic [AW-1:0] IER   = 9'd261;

  logic clk = 0;
  logic rst = 1;
  logic cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic rx_valid = 0;
  logic rx_ready;
  logic [31:0] rx_id = '0;
  logic [3:0] rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [15:0] rx_ts = '0;
  logic tx_valid;
  logic tx_ready = 0;
  logic [31:0] tx_id;
  logic [3:0] tx_dlc;
  logic [63:0] tx_data;
  logic [15:0] tx_ts;
  logic rx_overrun;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_msg_fifo_pair #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .rst(rst),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .rx_ts(rx_ts),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_dlc(tx_dlc),
    .tx_data(tx_data), .tx_ts(tx_ts),
    .rx_overrun(rx_overrun), .irq(irq)
  );

  function automatic logic [31:0] f_id(input int k);
    if (k % 2 == 1) f_id = 32'h8000_0000 | (32'h0123_4560 + 32'(k));
    else            f_id = (32'(11'h100 + 11'(k)) << 18) | ((k % 4 == 2) ? 32'h4000_0000 : 32'h0);
  endfunction
  function automatic logic [63:0] f_data(input int k);
    f_data = {8{8'(k + 1)}} ^ 64'h0011_2233_4455_6677;
  endfunction
  function automatic logic [3:0]  f_dlc(input int k); f_dlc = 4'((k + 3) % 9); endfunction
  function automatic logic [15:0] f_ts(input int k);  f_ts = 16'hA000 + 16'(k);  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic stage_tx(input int k);
    wr(TXW + 0, f_id(k));
    wr(TXW + 1, f_data(k)[31:0]);
    wr(TXW + 2, f_data(k)[63:32]);
    wr(TXW + 3, {f_ts(k), 12'h0, f_dlc(k)});
  endtask

  task automatic push_rx(input int k);
    @(negedge clk);
    rx_valid = 1; rx_id = f_id(k); rx_dlc = f_dlc(k); rx_data = f_data(k); rx_ts = f_ts(k);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    bit sticky;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(TXCTL, v); chk(v == 32'h00, "R1 txctl", v, 32'h00);
    rd(RXCTL, v); chk(v == 32'h80, "R1 rxctl", v, 32'h80);
    rd(ISR, v);   chk(v == 32'h00, "R1 isr", v, 0);
    rd(IER, v);   chk(v == 32'h00, "R1 ier", v, 0);
    chk({irq, tx_valid, rx_ready, rx_overrun} == 4'b0, "R1 outputs",
        {irq, tx_valid, rx_ready, rx_overrun}, 0);

    wr(TXCTL, 32'h1);
    wr(RXCTL, 32'h1);
    wr(IER, 32'h08);

    // R11 DLC masking and ID flags kept
    wr(TXW + 3, 32'hABCD_00FF); rd(TXW + 3, v);
    chk(v == 32'hABCD_000F, "R11 dlc mask", v, 32'hABCD_000F);
    wr(TXW + 0, 32'hC000_0ABC); rd(TXW + 0, v);
    chk(v == 32'hC000_0ABC, "R11 id flags", v, 32'hC000_0ABC);

    // R2 R3 fill sweep past full
    cnt = 0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      stage_tx(k);
      rd(TXW + 2, v); chk(v == f_data(k)[63:32], "R2 stage readback", v, f_data(k)[63:32]);
      wr(TXPTR, 32'hFE);
      rd(TXCTL, v); chk(v == (32'(cnt) << 1 | 32'(k > DEPTH) << 4 | 1), "R2 non-key write",
                        v, 32'(cnt) << 1 | 1);
      wr(TXPTR, 32'hFF);
      if (cnt < DEPTH) cnt++;
      rd(TXCTL, v);
      chk(v == ((32'(k >= DEPTH) << 4) | (32'(cnt) << 1) | 1), "R3 R2 txctl count/ovf",
          v, (32'(k >= DEPTH) << 4) | (32'(cnt) << 1) | 1);
    end
    wr(TXCTL, 32'h11);
    rd(TXCTL, v); chk(v == 32'h09, "R3 sticky clear", v, 32'h09);

    // R4 R9 drain in order
    for (int k = 0; k < DEPTH; k++) begin
      chk(tx_valid === 1'b1, "R4 tx_valid", tx_valid, 1);
      chk({tx_id, tx_dlc, tx_ts} == {f_id(k), f_dlc(k), f_ts(k)}, "R4 head fields",
          {tx_id, tx_dlc, tx_ts}, {f_id(k), f_dlc(k), f_ts(k)});
      chk(tx_data == f_data(k), "R4 head data", tx_data, f_data(k));
      pop_tx();
      chk(irq == 1'b0, "R9 irq not yet", irq, 0);
      @(negedge clk);
      chk(irq == 1'b1, "R9 irq one cycle later", irq, 1);
      rd(ISR, v); chk(v == 32'h08, "R9 tx flag", v, 32'h08);
      wr(ISR, 32'h10);
      rd(ISR, v); chk(v == 32'h00, "R9 flag cleared", v, 0);
    end
    chk(tx_valid == 1'b0, "R4 drained", tx_valid, 0);
    rd(TXCTL, v); chk(v == 32'h01, "R4 count zero", v, 32'h01);

    // R6 release on empty
    wr(RXPTR, 32'hFF);
    rd(RXCTL, v); chk(v == 32'h91, "R6 underflow sticky", v, 32'h91);
    wr(RXCTL, 32'h11);
    rd(RXCTL, v); chk(v == 32'h81, "R6 sticky clear", v, 32'h81);

    // R5 R7 R8 fill past full
    wr(IER, 32'h10);
    for (int k = 0; k < DEPTH + 1; k++) begin
      push_rx(10 + k);
      chk(rx_overrun == (k >= DEPTH), "R7 overrun pulse", rx_overrun, k >= DEPTH);
      @(negedge clk);
      chk(rx_overrun == 1'b0, "R7 pulse one cycle", rx_overrun, 0);
      cnt = (k + 1 > DEPTH) ? DEPTH : k + 1;
      rd(RXCTL, v); chk(v == ((32'(cnt) << 1) | 1), "R8 rx count", v, (32'(cnt) << 1) | 1);
    end
    rd(ISR, v); chk(v == 32'h10, "R9 rx flag", v, 32'h10);
    chk(irq == 1'b1, "R9 rx irq", irq, 1);
    wr(IER, 32'h00);
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    wr(ISR, 32'h00);

    for (int k = 0; k < DEPTH; k++) begin
      rd(RXW + 0, v); chk(v == f_id(10 + k), "R5 rx id", v, f_id(10 + k));
      rd(RXW + 1, v); chk(v == f_data(10 + k)[31:0], "R5 rx data lo", v, f_data(10 + k)[31:0]);
      rd(RXW + 2, v); chk(v == f_data(10 + k)[63:32], "R5 rx data hi", v, f_data(10 + k)[63:32]);
      rd(RXW + 3, v); chk(v == {f_ts(10 + k), 12'h0, f_dlc(10 + k)}, "R5 rx ts dlc",
                          v, {f_ts(10 + k), 12'h0, f_dlc(10 + k)});
      wr(RXPTR, 32'hFF);
      cnt = DEPTH - 1 - k;
      rd(RXCTL, v); chk(v == ((32'(cnt == 0) << 7) | (32'(cnt) << 1) | 1), "R8 rx drain",
                        v, (32'(cnt == 0) << 7) | (32'(cnt) << 1) | 1);
    end

    // R10 disable flushes and blocks
    push_rx(30); push_rx(31);
    wr(RXCTL, 32'h0);
    chk(rx_ready == 1'b0, "R10 rx_ready low", rx_ready, 0);
    push_rx(32);
    rd(RXCTL, v); chk(v == 32'h80, "R10 rx flushed", v, 32'h80);
    wr(RXCTL, 32'h1);
    rd(RXCTL, v); chk(v == 32'h81, "R10 rx reenabled empty", v, 32'h81);
    stage_tx(40); wr(TXPTR, 32'hFF); wr(TXPTR, 32'hFF);
    wr(TXCTL, 32'h0);
    wr(TXPTR, 32'hFF);
    rd(TXCTL, v); chk(v == 32'h00, "R10 tx flushed", v, 0);
    chk(tx_valid == 1'b0, "R10 tx_valid low", tx_valid, 0);
    wr(TXCTL, 32'h1);
    rd(TXCTL, v); chk(v == 32'h01, "R10 tx reenabled empty", v, 32'h01);
    sticky = 0;

    done = 1;
    finish_run();
  end

endmodule